// File: doc/BRIEF.md
# Paired-Page Event State Access Unit

This block holds two 2-bit pending/queued (P/Q) event states for every one of `NUM_QUEUES` event queues and lets software work on them through 8-byte memory-mapped loads and stores. Every queue owns two adjacent pages. The even page reaches the queue's notification state, and the odd page reaches its escalation state. The address splits into a queue index (above the page pair), a page-parity bit, and a 12-bit operation offset within the page. The offset selects the operation and, for the set operations, carries the new state.

A request is taken in the cycle that `req_valid` is high. The block answers one cycle later with `rsp_valid`, the load data, an error flag, and (for stores whose event must travel on) a one-cycle `notify` pulse. The pulse is tagged with the queue index and the page parity. The block does not route the event any further. The P/Q value is shown with P in data bit 1 and Q in data bit 0.

The page shift is a parameter that may be 12 (4 KiB pages) or 16 (64 KiB pages). Elaboration stops with an error for any other value.

Top module: `evstate_mmio`

## Requirements
- R1: Every request with `req_valid` high produces `rsp_valid` high in the next cycle. `rsp_valid` is low in every other cycle, and `rsp_data` is zero whenever `rsp_valid` is low.
- R2: The queue index is `req_addr >> (PAGE_SHIFT+1)`. Address bit `PAGE_SHIFT` at 0 selects the notification state and at 1 selects the escalation state. The two states of a queue never affect each other.
- R3: A load at offset 0x000–0x7FF performs an end-of-interrupt on the selected state. The transitions are 00→00, 10→00 and 11→10, and 01 stays 01. Data bit 0 is 1 only for the 11 case. All other data bits are zero.
- R4: A load at offset 0x800–0xBFF returns the current state in data bits [1:0] and leaves it unchanged.
- R5: A load at offset 0xC00–0xFFF returns the old state in bits [1:0] and then writes offset bit 9 into P and offset bit 8 into Q.
- R6: A store at offset 0x000–0x3FF is a trigger. State 00 becomes 10 and raises `notify`. State 10 becomes 11 without `notify`. States 01 and 11 stay unchanged without `notify`.
- R7: A store at offset 0x400–0x7FF is a store-EOI. It makes the same transition as R3 and raises `notify` only for the 11 case.
- R8: A store at offset 0x800–0xBFF is an inject. On an even page it raises `notify` and leaves the state unchanged. On an odd page it sets `error`, changes nothing and raises no `notify`.
- R9: A request with `req_size` other than 8 sets `error`, returns zero data, raises no `notify` and changes no state.
- R10: A store at offset 0xC00–0xFFF, or any request whose queue index is `NUM_QUEUES` or more, sets `error`, returns zero data and changes no state.
- R11: After reset, all states are 00 and `rsp_valid`, `error` and `notify` are low.
- R12: When `notify` is high, `notify_queue` holds the queue index and `notify_escal` holds the page parity of the request that caused it. `error` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Byte address of the access |
| req_size | input | 4 | Access size in bytes; only 8 is accepted |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_data | output | 64 | Load data; P in bit 1, Q in bit 0 (or the EOI result in bit 0) |
| error | output | 1 | The previous request was rejected |
| notify | output | 1 | One-cycle pulse: forward an event |
| notify_queue | output | QW | Queue index of the notifying request |
| notify_escal | output | 1 | 1 if the notifying request hit an escalation page |

## Verification
A directed phase walks one queue through every state under triggers, both EOI forms, gets and all four set values. Firing triggers on the even page of a queue and then reading its odd page separates the two per-queue states. A mapping that mixes up P/Q pairs or queue indices shows up as a wrong get result. Single rejected cases follow: an inject on an odd page, a store at the unassigned offset range, a wrong access size and an out-of-range queue index. Each is followed by a get, which shows that no state moved. A long pseudo-random phase then mixes indices just past the queue count, both parities, every offset range and occasional wrong sizes. A behavioural reference model checks every cycle, which exposes ordering and back-to-back write hazards that the directed phase cannot reach.

// File: rtl/evstate_mmio.sv
module evstate_mmio #(
  parameter int NUM_QUEUES = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int ADDR_W     = 20,
  localparam int QW        = (NUM_QUEUES > 1) ? $clog2(NUM_QUEUES) : 1,
  localparam int IDX_W     = ADDR_W - PAGE_SHIFT - 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_size,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic              error,
  output logic              notify,
  output logic [QW-1:0]     notify_queue,
  output logic              notify_escal
);

  generate
    if (PAGE_SHIFT != 12 && PAGE_SHIFT != 16) begin : g_bad_shift
      $error("evstate_mmio: PAGE_SHIFT must be 12 or 16");
    end
    if (IDX_W < QW) begin : g_bad_width
      $error("evstate_mmio: ADDR_W too small for NUM_QUEUES");
    end
  endgenerate

  // {ret, next}
  function automatic logic [2:0] eoi_f(input logic [1:0] s);
    case (s)
      2'b11:   return {1'b1, 2'b10};
      2'b10:   return {1'b0, 2'b00};
      default: return {1'b0, s};
    endcase
  endfunction

  // {notify, next}
  function automatic logic [2:0] trig_f(input logic [1:0] s);
    case (s)
      2'b00:   return {1'b1, 2'b10};
      2'b10:   return {1'b0, 2'b11};
      default: return {1'b0, s};
    endcase
  endfunction

  logic [1:0] ntf_pq [NUM_QUEUES];
  logic [1:0] esc_pq [NUM_QUEUES];

  wire [IDX_W-1:0] raw_idx = req_addr[ADDR_W-1:PAGE_SHIFT+1];
  wire             odd     = req_addr[PAGE_SHIFT];
  wire [11:0]      off     = req_addr[11:0];
  wire             size_ok = (req_size == 4'd8);
  wire             idx_ok  = (raw_idx < IDX_W'(NUM_QUEUES));
  wire [QW-1:0]    qidx    = raw_idx[QW-1:0];
  wire [1:0]       cur     = odd ? esc_pq[qidx] : ntf_pq[qidx];

  logic [1:0]  nxt;
  logic [63:0] rdata;
  logic        ntfy;
  logic        err;
  logic [2:0]  eo;
  logic [2:0]  tr;

  assign eo = eoi_f(cur);
  assign tr = trig_f(cur);

  always_comb begin
    nxt   = cur;
    rdata = '0;
    ntfy  = 1'b0;
    err   = 1'b0;
    if (!size_ok || !idx_ok) begin
      err = 1'b1;
    end else if (!req_write) begin
      if (!off[11]) begin
        nxt      = eo[1:0];
        rdata[0] = eo[2];
      end else if (!off[10]) begin
        rdata[1:0] = cur;
      end else begin
        rdata[1:0] = cur;
        nxt        = off[9:8];
      end
    end else begin
      case (off[11:10])
        2'b00: begin nxt = tr[1:0]; ntfy = tr[2]; end
        2'b01: begin nxt = eo[1:0]; ntfy = eo[2]; end
        2'b10: begin
          if (odd) err = 1'b1;
          else     ntfy = 1'b1;
        end
        default: err = 1'b1;
      endcase
    end
  end

  wire do_write = req_valid && !err && (nxt != cur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_QUEUES; i++) begin
        ntf_pq[i] <= 2'b00;
        esc_pq[i] <= 2'b00;
      end
    end else if (do_write) begin
      if (odd) esc_pq[qidx] <= nxt;
      else     ntf_pq[qidx] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid    <= 1'b0;
      rsp_data     <= '0;
      error        <= 1'b0;
      notify       <= 1'b0;
      notify_queue <= '0;
      notify_escal <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_data  <= req_valid ? rdata : '0;
      error     <= req_valid && err;
      notify    <= req_valid && ntfy;
      if (req_valid) begin
        notify_queue <= qidx;
        notify_escal <= odd;
      end
    end
  end

  assert_rsp_follows_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && rsp_data == 64'd0));
  assert_get_keeps_state_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && size_ok && idx_ok && off[11:10] == 2'b10)
      |=> (ntf_pq[$past(qidx)] == $past(ntf_pq[qidx]) &&
           esc_pq[$past(qidx)] == $past(esc_pq[qidx])));
  assert_trigger_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && size_ok && idx_ok && off[11:10] == 2'b00 && cur == 2'b00)
      |=> notify);
  assert_odd_inject_rejected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && odd && off[11:10] == 2'b10) |=> (error && !notify));
  assert_bad_size_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !size_ok) |=> (error && !notify && rsp_data == 64'd0));
  assert_notify_clean_R12: assert property (@(posedge clk) disable iff (!rst_n)
    notify |-> (rsp_valid && !error));

endmodule

// File: tb/sim_evstate_mmio.sv
module sim_evstate_mmio;
  localparam int PERIOD = 10;
  localparam int NQ     = 16;
  localparam int SHIFT  = 12;
  localparam int AW     = 20;
  localparam int QW     = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [3:0]    req_size = 4'd8;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic          error;
  logic          notify;
  logic [QW-1:0] notify_queue;
  logic          notify_escal;

  always #(PERIOD/2) clk = ~clk;

  evstate_mmio #(.NUM_QUEUES(NQ), .PAGE_SHIFT(SHIFT), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .rsp_valid(rsp_valid),
    .rsp_data(rsp_data), .error(error), .notify(notify),
    .notify_queue(notify_queue), .notify_escal(notify_escal));

  int ntf [NQ];
  int esc [NQ];
  int vectors = 0;
  int fails = 0;
  bit done = 0;

  bit     e_valid, e_err, e_ntf, e_esc;
  longint e_data;
  int     e_q;
  string  e_tag = "R11";

  function automatic void fail(string tag, string what, longint act, longint exp);
    fails++;
    $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
  endfunction

  task automatic compare();
    bit bad = 0;
    vectors++;
    if (rsp_valid !== e_valid) begin fail({e_tag, "/R1"}, "rsp_valid", rsp_valid, e_valid); bad = 1; end
    if (!bad && rsp_data !== e_data) begin fail(e_tag, "rsp_data", rsp_data, e_data); bad = 1; end
    if (!bad && error !== e_err) begin fail(e_tag, "error", error, e_err); bad = 1; end
    if (!bad && notify !== e_ntf) begin fail({e_tag, "/R12"}, "notify", notify, e_ntf); bad = 1; end
    if (!bad && e_ntf && notify_queue !== QW'(e_q)) fail({e_tag, "/R12"}, "notify_queue", notify_queue, e_q);
    else if (!bad && e_ntf && notify_escal !== e_esc) fail({e_tag, "/R12"}, "notify_escal", notify_escal, e_esc);
  endtask

  // reference model: computes expected outputs of the following cycle
  task automatic model(bit v, bit w, int q, bit odd, int off, int sz);
    int p, np, d;
    bit nt, er;
    string tg;
    e_valid = v; e_data = 0; e_err = 0; e_ntf = 0; e_q = q; e_esc = odd;
    e_tag = "R1";
    if (!v) return;
    p = 0; np = 0; d = 0; nt = 0; er = 0;
    if (q < NQ) p = odd ? esc[q] : ntf[q];
    np = p;
    if (sz != 8) begin er = 1; tg = "R9"; end
    else if (q >= NQ) begin er = 1; tg = "R10"; end
    else if (!w) begin
      if (off < 'h800) begin
        tg = "R3";
        if (p == 3) begin np = 2; d = 1; end else if (p == 2) np = 0;
      end else if (off < 'hC00) begin tg = "R4"; d = p; end
      else begin tg = "R5"; d = p; np = (off >> 8) & 3; end
    end else begin
      if (off < 'h400) begin
        tg = "R6";
        if (p == 0) begin np = 2; nt = 1; end else if (p == 2) np = 3;
      end else if (off < 'h800) begin
        tg = "R7";
        if (p == 3) begin np = 2; nt = 1; end else if (p == 2) np = 0;
      end else if (off < 'hC00) begin
        tg = "R8";
        if (odd) er = 1; else nt = 1;
      end else begin er = 1; tg = "R10"; end
    end
    if (!er) begin
      if (odd) esc[q] = np; else ntf[q] = np;
      if (odd) tg = {tg, "/R2"};
    end
    e_data = er ? 0 : d; e_err = er; e_ntf = nt; e_tag = tg;
  endtask

  task automatic step(bit v, bit w, int q, bit odd, int off, int sz);
    @(negedge clk);
    compare();
    req_valid = v;
    req_write = w;
    req_addr  = AW'((q << (SHIFT + 1)) | (int'(odd) << SHIFT) | (off & 'hFFF));
    req_size  = 4'(sz);
    model(v, w, q, odd, off, sz);
  endtask

  task automatic ld(int q, bit odd, int off); step(1, 0, q, odd, off, 8); endtask
  task automatic st(int q, bit odd, int off); step(1, 1, q, odd, off, 8); endtask

  initial begin
    for (int i = 0; i < NQ; i++) begin ntf[i] = 0; esc[i] = 0; end
    e_valid = 0; e_data = 0; e_err = 0; e_ntf = 0; e_q = 0; e_esc = 0;
    repeat (3) @(negedge clk);
    e_tag = "R11";
    compare();                       // R11 outputs during reset
    rst_n = 1'b1;
    ld(5, 0, 'h800);                 // R11 state reads 00
    ld(5, 1, 'h800);
    st(5, 0, 'h000);                 // R6 00->10 notify
    st(5, 0, 'h010);                 // R6 10->11
    st(5, 0, 'h3F8);                 // R6 11 stays
    ld(5, 1, 'h900);                 // R2 odd page still 00
    ld(5, 0, 'h800);                 // R4 reads 11
    ld(5, 0, 'h000);                 // R3 11->10, returns 1
    ld(5, 0, 'h7F8);                 // R3 10->00
    ld(5, 0, 'h400);                 // R3 00 stays
    ld(5, 0, 'hD00);                 // R5 old 00, write 01
    st(5, 0, 'h000);                 // R6 01 stays, no notify
    ld(5, 0, 'h000);                 // R3 01 stays
    ld(5, 0, 'hF00);                 // R5 write 11
    st(5, 0, 'h400);                 // R7 11->10 notify
    st(5, 0, 'h400);                 // R7 10->00
    ld(5, 0, 'hE00);                 // R5 write 10
    ld(5, 0, 'hC00);                 // R5 old 10, write 00
    st(9, 1, 'h000);                 // R6 escalation trigger, R12 tags
    st(9, 1, 'h800);                 // R8 odd inject rejected
    ld(9, 1, 'h800);                 // R8 no change: still 10
    st(3, 0, 'h800);                 // R8 even inject notifies
    ld(3, 0, 'h800);                 // R8 no change: 00
    st(3, 0, 'hC00);                 // R10 unknown store offset
    ld(3, 0, 'h800);
    step(1, 1, 3, 0, 'h000, 4);      // R9 wrong size
    ld(3, 0, 'h800);                 // R9 no change
    st(16, 0, 'h000);                // R10 out-of-range queue
    ld(0, 0, 'h800);                 // R10 queue 0 untouched
    step(0, 0, 0, 0, 0, 8);          // R1 idle
    begin
      int unsigned s = 32'h1234_5678;
      for (int n = 0; n < 4000; n++) begin
        int q, off, sz;
        bit v, w, od;
        s ^= s << 13; s ^= s >> 17; s ^= s << 5;
        v   = (s[2:0] != 3'd0);
        w   = s[3];
        od  = s[4];
        q   = int'(s[9:5]) % (NQ + 4);
        off = int'(s[21:10]);
        sz  = (s[26:23] == 4'd0) ? int'(s[30:27]) : 8;
        step(v, w, q, od, off, sz);
      end
    end
    @(negedge clk);
    compare();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule